// File: doc/BRIEF.md
# Crystal Parabolic Drift Calculator

This block estimates how far a 32 kHz tuning-fork crystal runs from its nominal frequency at a given temperature. The crystal follows a downward parabola around its turnover temperature. The block takes a signed temperature sample in half-degree units and a 5-bit turnover code. It squares the distance from the turnover point and scales that square by a curvature coefficient. It returns the deviation as a signed fixed-point ppm value.

Two 7-bit curvature coefficients are held inside the block. One serves temperatures at or above the turnover point, and the other serves temperatures below it. Each coefficient holds the magnitude of the crystal's curvature in ppm/°C², multiplied by 2048. A typical value of -0.034 is stored as 70. Both registers load preset values at reset. A write port can overwrite them, but only while temperature sensing is switched off. The calculation is a three-stage pipeline. It accepts one sample per cycle and marks each result with a single-cycle valid pulse.

Top module: `xtal_drift_calc`

## Requirements
- R1: After reset, `drift_valid` is 0 and `drift` is 0. The hot coefficient holds `HOT_PRESET` (default 70) and the cold coefficient holds `COLD_PRESET` (default 72).
- R2: The turnover temperature in half-degree units is 50 + m when `turn_code[4]` is 0, and 50 - m when it is 1, where m = `turn_code[3:0]`. Code 01111 therefore gives 32.5 °C and code 11111 gives 17.5 °C.
- R3: Codes 00000 and 10000 both give a turnover of 25.0 °C and produce identical results.
- R4: With d = sample - turnover in half-degree units, the hot coefficient is used when d >= 0 and the cold coefficient is used when d < 0.
- R5: `drift` = -floor(coef × d² / 32), in two's complement with 8 fractional bits. This equals -(coef/2048)·(ΔT °C)² ppm, with the magnitude truncated.
- R6: When `wr_en` is 1 and `sense_en` is 0, the coefficient selected by `wr_hot` is loaded from `wr_data` (1 selects hot, 0 selects cold). When `sense_en` is 1, the write is ignored.
- R7: A result appears with `drift_valid` high for exactly one cycle, three clock edges after the edge that samples `smp_valid`. Between valid pulses, `drift` holds its last value.
- R8: A sample taken on the same edge as an accepted coefficient write uses the coefficient value held before that write.
- R9: Samples on consecutive cycles each produce their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_en | input | 1 | Temperature sensing active; blocks coefficient writes |
| wr_en | input | 1 | Coefficient write strobe |
| wr_hot | input | 1 | Write target: 1 hot, 0 cold |
| wr_data | input | CW | Scaled coefficient to write |
| turn_code | input | 5 | Turnover code, sign-magnitude around 25.0 °C |
| smp_valid | input | 1 | Temperature sample strobe |
| smp_temp | input | TW | Signed temperature, 0.5 °C units |
| drift_valid | output | 1 | Result strobe |
| drift | output | OW | Signed ppm deviation, 8 fractional bits |

## Verification
A coefficient write and a sample capture can fall on the same clock edge. The bench provokes this with a write to the hot coefficient issued together with a sample above the turnover point. The result must match a model that uses the old coefficient, and a sample taken on the next cycle must use the new one. The bench also issues a write while sensing is enabled and follows it with samples. Those results must keep using the unchanged coefficient.

// File: rtl/xtal_drift_calc.sv
module xtal_drift_calc #(
  parameter int TW = 10,
  parameter int CW = 7,
  parameter int FRAC = 8,
  parameter int HOT_PRESET = 70,
  parameter int COLD_PRESET = 72,
  localparam int DW = TW + 1,
  localparam int PW = 2 * DW + CW,
  localparam int SH = 13 - FRAC,
  localparam int OW = PW - SH + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sense_en,
  input  logic                 wr_en,
  input  logic                 wr_hot,
  input  logic [CW-1:0]        wr_data,
  input  logic [4:0]           turn_code,
  input  logic                 smp_valid,
  input  logic signed [TW-1:0] smp_temp,
  output logic                 drift_valid,
  output logic signed [OW-1:0] drift
);

  logic [CW-1:0] hot_q, cold_q, c1;
  logic signed [DW-1:0] t0, diff, d1;
  logic [DW-1:0] mag, ad;
  logic [PW-1:0] p2;
  logic v1, v2;

  assign mag  = DW'(turn_code[3:0]);
  assign t0   = turn_code[4] ? DW'(50) - mag : DW'(50) + mag;
  assign diff = DW'(smp_temp) - t0;
  assign ad   = d1[DW-1] ? -d1 : d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q  <= CW'(HOT_PRESET);
      cold_q <= CW'(COLD_PRESET);
    end else if (wr_en && !sense_en) begin
      if (wr_hot) hot_q <= wr_data;
      else        cold_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      drift_valid <= 1'b0;
      d1 <= '0;
      c1 <= '0;
      p2 <= '0;
      drift <= '0;
    end else begin
      v1 <= smp_valid;
      v2 <= v1;
      drift_valid <= v2;
      if (smp_valid) begin
        d1 <= diff;
        c1 <= diff[DW-1] ? cold_q : hot_q;
      end
      if (v1) p2 <= PW'(c1) * PW'(ad) * PW'(ad);
      if (v2) drift <= -$signed(OW'(p2 >> SH));
    end
  end

endmodule

module xtal_drift_calc_chk #(
  parameter int CW = 7,
  parameter int OW = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sense_en,
  input logic          wr_en,
  input logic          smp_valid,
  input logic          drift_valid,
  input logic [OW-1:0] drift,
  input logic [CW-1:0] hot_q,
  input logic [CW-1:0] cold_q
);

  // R7
  latency_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> ##2 drift_valid);

  // R7
  latency_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drift_valid |-> $past(smp_valid, 3));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drift_valid |-> $stable(drift));

  // R5
  nonpositive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drift_valid |-> (drift[OW-1] || drift == '0));

  // R6
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_en && wr_en) |=> ($stable(hot_q) && $stable(cold_q)));

endmodule

bind xtal_drift_calc xtal_drift_calc_chk #(.CW(CW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sense_en(sense_en), .wr_en(wr_en),
  .smp_valid(smp_valid), .drift_valid(drift_valid), .drift(drift),
  .hot_q(hot_q), .cold_q(cold_q)
);

// File: tb/xtal_drift_calc_test.sv
module xtal_drift_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 10;
  localparam int CW = 7;
  localparam int OW = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense_en = 1'b0, wr_en = 1'b0, wr_hot = 1'b0, smp_valid = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic [4:0] turn_code = '0;
  logic signed [TW-1:0] smp_temp = '0;
  logic drift_valid;
  logic signed [OW-1:0] drift;

  xtal_drift_calc uut (
    .clk(clk), .rst_n(rst_n), .sense_en(sense_en), .wr_en(wr_en),
    .wr_hot(wr_hot), .wr_data(wr_data), .turn_code(turn_code),
    .smp_valid(smp_valid), .smp_temp(smp_temp),
    .drift_valid(drift_valid), .drift(drift)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int due; longint val; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0, cycle = 0;
  int m_hot = 70, m_cold = 72;
  longint last = 0;

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cycle++;
    if (q.size() > 0 && q[0].due == cycle) begin
      check(drift_valid == 1'b1, {q[0].tag, " R7 valid"}, drift_valid, 1);
      check(longint'(drift) == q[0].val, q[0].tag, drift, q[0].val);
      last = q[0].val;
      void'(q.pop_front());
    end else begin
      check(drift_valid == 1'b0, "R7 idle valid", drift_valid, 0);
      check(longint'(drift) == last, "R7 hold", drift, last);
    end
  endtask

  task automatic put(bit sv, int temp, bit [4:0] code, bit we, bit hot,
                     int data, bit tse, string tag);
    longint t0, d, c;
    exp_t e;
    smp_valid = sv; smp_temp = TW'(temp); turn_code = code;
    wr_en = we; wr_hot = hot; wr_data = CW'(data); sense_en = tse;
    if (sv) begin
      t0 = code[4] ? 50 - longint'(code[3:0]) : 50 + longint'(code[3:0]);
      d = temp - t0;
      c = (d >= 0) ? m_hot : m_cold;
      e.due = cycle + 3;
      e.val = -((c * d * d) / 32);
      e.tag = tag;
      q.push_back(e);
    end
    if (we && !tse) begin
      if (hot) m_hot = data; else m_cold = data;
    end
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) put(0, 0, 5'd0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    check(drift_valid == 1'b0, "R1 reset valid", drift_valid, 0);
    check(drift == '0, "R1 reset drift", drift, 0);
    idle(2);
    // R1 presets observed through results
    put(1, 100, 5'b00000, 0, 0, 0, 0, "R1 hot preset");
    put(1, 0, 5'b00000, 0, 0, 0, 0, "R1 cold preset");
    idle(4);
    // R2 turnover decoding
    put(1, 65, 5'b01111, 0, 0, 0, 0, "R2 code 01111");
    put(1, 35, 5'b11111, 0, 0, 0, 0, "R2 code 11111");
    put(1, 70, 5'b00011, 0, 0, 0, 0, "R2 code 00011");
    put(1, 70, 5'b10011, 0, 0, 0, 0, "R2 code 10011");
    idle(4);
    // R3 two codes for 25.0
    put(1, 60, 5'b00000, 0, 0, 0, 0, "R3 code 00000");
    put(1, 60, 5'b10000, 0, 0, 0, 0, "R3 code 10000");
    put(1, 38, 5'b10000, 0, 0, 0, 0, "R3 code 10000 cold");
    idle(4);
    // R4 coefficient choice at the boundary
    put(1, 54, 5'b00100, 0, 0, 0, 0, "R4 at turnover");
    put(1, 53, 5'b00100, 0, 0, 0, 0, "R4 below uses cold");
    put(1, 55, 5'b00100, 0, 0, 0, 0, "R4 above uses hot");
    idle(4);
    // R6 write while sensing is ignored
    put(0, 0, 5'd0, 1, 1, 100, 1, "R6 locked hot");
    put(0, 0, 5'd0, 1, 0, 5, 1, "R6 locked cold");
    put(1, 90, 5'b00000, 0, 0, 0, 0, "R6 hot unchanged");
    put(1, 10, 5'b00000, 0, 0, 0, 0, "R6 cold unchanged");
    idle(3);
    put(0, 0, 5'd0, 1, 1, 41, 0, "R6 write hot");
    put(0, 0, 5'd0, 1, 0, 123, 0, "R6 write cold");
    put(1, 90, 5'b00000, 0, 0, 0, 0, "R6 hot written");
    put(1, 10, 5'b00000, 0, 0, 0, 0, "R6 cold written");
    idle(4);
    // R8 sample and write on the same edge
    put(1, 80, 5'b00000, 1, 1, 127, 0, "R8 same-edge old coef");
    put(1, 80, 5'b00000, 0, 0, 0, 0, "R8 next uses new coef");
    idle(4);
    // R9 back-to-back samples and R5 extremes
    put(1, 511, 5'b11111, 0, 0, 0, 0, "R9 R5 max hot");
    put(0, 0, 5'd0, 1, 0, 127, 0, "R6 cold to 127");
    put(1, -512, 5'b01111, 0, 0, 0, 0, "R9 R5 max cold");
    put(1, 51, 5'b00000, 0, 0, 0, 0, "R9 R5 tiny");
    put(1, 57, 5'b00000, 0, 0, 0, 0, "R9 R5 small");
    put(1, -40, 5'b10101, 0, 0, 0, 0, "R9 R5 negative temp");
    put(1, 200, 5'b01010, 0, 0, 0, 0, "R9 R5 hot run");
    idle(6);
    check(q.size() == 0, "R7 all results seen", q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule